// File: doc/BRIEF.md
# Suspend Modulation Throttle Generator

This block lowers the effective speed of a processor core by pulsing an active-low suspend output. While modulation is enabled it alternates between a run phase, in which the suspend output is high and the core executes, and a suspend phase, in which the output is low and the core idles. Each phase lasts a programmable number of base ticks. The base tick is nominally 32 µs and is taken from the system clock through a parameterised prescaler. The core then runs at its full speed scaled by run / (run + suspend).

A byte-wide register port holds the two phase lengths, a modulation configuration byte, a power-management enable byte, and two speedup durations. When its enable bit is set, an interrupt event or a video event stops throttling for a programmed number of milliseconds. During that window the core runs at full speed. When the window closes, modulation restarts with a fresh run phase.

Top module: `suspmod_throttle`

## Requirements
- R1: After reset every register reads back 0x00 and `susp_n` is 1.
- R2: Registers are decoded at these byte addresses: power-management enable 0x80, interrupt speedup duration 0x8C, video speedup duration 0x8D, run-phase length 0x94, suspend-phase length 0x95, modulation configuration 0x96. A write stores all 8 bits, and the stored value appears combinationally on `reg_rdata` when `reg_addr` selects it. Any other address reads 0x00, and writes to it change nothing.
- R3: While bit 0 of the configuration register is 0, `susp_n` stays 1.
- R4: With modulation enabled, each phase starts and ends only on a base tick, which fires once every TICK_DIV clocks. A cycle starts with the run phase, which holds `susp_n` high for the run-phase length in ticks. The suspend phase follows and holds `susp_n` low for the suspend-phase length in ticks. The two phases then repeat.
- R5: A phase whose length is zero is skipped. If both lengths are zero, `susp_n` stays 1. If only the run length is zero, `susp_n` stays 0.
- R6: Writing a new phase length does not shorten or lengthen the phase in progress. The new length is used the next time that phase starts.
- R7: While bit 3 of the power-management enable register is 1, a one-clock pulse on `irq_evt` loads the interrupt speedup timer with its duration register. The timer counts down one step per millisecond, and a millisecond is MS_TICKS base ticks. While the timer is non-zero, throttling stops and `susp_n` is 1. A new pulse reloads the timer. While bit 3 is 0, the pulse is ignored.
- R8: Bit 4 of the power-management enable register and the `vid_evt` input control a second, independent speedup timer. This timer loads from the video speedup duration register and behaves exactly as in R7.
- R9: When the speedup window ends, modulation resumes with a complete run phase that starts at the next base tick.
- R10: Bits 0 to 2 of the power-management enable register are stored only. They have no effect on `susp_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low core suspend request |

## Verification
The hardest case to reach is a speedup timer reload while the timer is still counting. It has to line up with the millisecond prescaler so that the remaining time is neither added to nor dropped. The stimulus fires a second interrupt pulse partway through a window and then lets the window expire. This also reaches the restart into a fresh run phase. A write to a phase length in the middle of a phase is timed the same way, to prove the running phase completes at its old length. A behavioural model in the bench tracks the prescaler, the timers and the phases and is compared on every clock.

// File: rtl/suspmod_pkg.sv
package suspmod_pkg;
  localparam logic [7:0] A_PMEN = 8'h80;
  localparam logic [7:0] A_IRQ_DUR = 8'h8C;
  localparam logic [7:0] A_VID_DUR = 8'h8D;
  localparam logic [7:0] A_RUN_LEN = 8'h94;
  localparam logic [7:0] A_SUSP_LEN = 8'h95;
  localparam logic [7:0] A_MODCFG = 8'h96;

  localparam int PM_IRQ_BIT = 3;
  localparam int PM_VID_BIT = 4;
  localparam int CFG_MOD_BIT = 0;
  localparam int N_SPEEDUP = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_SUSP = 2'd2
  } phase_e;

  typedef struct packed {
    logic [7:0] pmen;
    logic [7:0] irq_dur;
    logic [7:0] vid_dur;
    logic [7:0] run_len;
    logic [7:0] susp_len;
    logic [7:0] modcfg;
  } regs_t;
endpackage

// File: rtl/suspmod_prescaler.sv
module suspmod_prescaler #(
  parameter int TICK_DIV = 4000,
  parameter int MS_TICKS = 31
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_base,
  output logic tick_ms
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MS_W = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_TICKS - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [MS_W-1:0] ms_q, ms_d;
  logic ms_en;

  assign tick_base = (div_q == DIV_LAST);
  assign tick_ms = tick_base && (ms_q == MS_LAST);
  assign ms_en = tick_base;

  always_comb begin
    div_d = tick_base ? '0 : div_q + 1'b1;
    ms_d = ms_q;
    if (ms_en) ms_d = (ms_q == MS_LAST) ? '0 : ms_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ms_q <= '0;
    end else begin
      div_q <= div_d;
      if (ms_en) ms_q <= ms_d;
    end
  end
endmodule

// File: rtl/suspmod_regfile.sv
module suspmod_regfile
  import suspmod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output regs_t      regs
);
  regs_t regs_q, regs_d;

  always_comb begin
    regs_d = regs_q;
    if (we) begin
      unique case (addr)
        A_PMEN:     regs_d.pmen = wdata;
        A_IRQ_DUR:  regs_d.irq_dur = wdata;
        A_VID_DUR:  regs_d.vid_dur = wdata;
        A_RUN_LEN:  regs_d.run_len = wdata;
        A_SUSP_LEN: regs_d.susp_len = wdata;
        A_MODCFG:   regs_d.modcfg = wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      A_PMEN:     rdata = regs_q.pmen;
      A_IRQ_DUR:  rdata = regs_q.irq_dur;
      A_VID_DUR:  rdata = regs_q.vid_dur;
      A_RUN_LEN:  rdata = regs_q.run_len;
      A_SUSP_LEN: rdata = regs_q.susp_len;
      A_MODCFG:   rdata = regs_q.modcfg;
      default:    rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else if (we) regs_q <= regs_d;
  end

  assign regs = regs_q;
endmodule

// File: rtl/suspmod_speedup.sv
module suspmod_speedup #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             enable,
  input  logic             event_in,
  input  logic [CNT_W-1:0] duration,
  output logic             active
);
  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic load, dec, tmr_en;

  assign load = enable && event_in;
  assign dec = tick_ms && (tmr_q != '0);
  assign tmr_en = load || dec;

  always_comb begin
    if (load) tmr_d = duration;
    else tmr_d = tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  assign active = enable && (tmr_q != '0);
endmodule

// File: rtl/suspmod_phase.sv
module suspmod_phase
  import suspmod_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             throttle_on,
  input  logic [LEN_W-1:0] run_len,
  input  logic [LEN_W-1:0] susp_len,
  output logic [1:0]       phase,
  output logic             susp_n
);
  phase_e st_q, st_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic boundary;
  logic want_run;

  assign boundary = tick && (rem_q <= 1);
  assign want_run = (st_q != PH_RUN);

  always_comb begin
    st_d = st_q;
    rem_d = rem_q;
    if (!throttle_on) begin
      st_d = PH_IDLE;
      rem_d = '0;
    end else if (boundary) begin
      if (want_run && run_len != '0) begin
        st_d = PH_RUN;
        rem_d = run_len;
      end else if (susp_len != '0) begin
        st_d = PH_SUSP;
        rem_d = susp_len;
      end else if (run_len != '0) begin
        st_d = PH_RUN;
        rem_d = run_len;
      end else begin
        st_d = PH_IDLE;
        rem_d = '0;
      end
    end else if (tick) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE;
      rem_q <= '0;
    end else begin
      st_q <= st_d;
      rem_q <= rem_d;
    end
  end

  assign phase = st_q;
  assign susp_n = (st_q != PH_SUSP);
endmodule

// File: rtl/suspmod_throttle.sv
module suspmod_throttle
  import suspmod_pkg::*;
#(
  parameter int TICK_DIV = 4000,
  parameter int MS_TICKS = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       irq_evt,
  input  logic       vid_evt,
  output logic       susp_n
);
  logic rs1_q, rs2_q;
  logic core_rst_n;
  logic tick_base, tick_ms;
  regs_t regs;
  logic [N_SPEEDUP-1:0] spd_evt, spd_en, spd_act;
  logic [7:0] spd_dur [N_SPEEDUP];
  logic spd_any, throttle_on;
  logic [1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign core_rst_n = rs2_q;

  suspmod_prescaler #(.TICK_DIV(TICK_DIV), .MS_TICKS(MS_TICKS)) u_pre (
    .clk(clk), .rst_n(core_rst_n), .tick_base(tick_base), .tick_ms(tick_ms)
  );

  suspmod_regfile u_regs (
    .clk(clk), .rst_n(core_rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .regs(regs)
  );

  assign spd_evt = {vid_evt, irq_evt};
  assign spd_en = {regs.pmen[PM_VID_BIT], regs.pmen[PM_IRQ_BIT]};
  assign spd_dur[0] = regs.irq_dur;
  assign spd_dur[1] = regs.vid_dur;

  for (genvar g = 0; g < N_SPEEDUP; g++) begin : g_spd
    suspmod_speedup #(.CNT_W(8)) u_tmr (
      .clk(clk), .rst_n(core_rst_n), .tick_ms(tick_ms), .enable(spd_en[g]),
      .event_in(spd_evt[g]), .duration(spd_dur[g]), .active(spd_act[g])
    );
  end

  assign spd_any = |spd_act;
  assign throttle_on = regs.modcfg[CFG_MOD_BIT] && !spd_any;

  suspmod_phase #(.LEN_W(8)) u_phase (
    .clk(clk), .rst_n(core_rst_n), .tick(tick_base), .throttle_on(throttle_on),
    .run_len(regs.run_len), .susp_len(regs.susp_len), .phase(phase), .susp_n(susp_n)
  );
endmodule

// File: rtl/suspmod_checker.sv
module suspmod_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       throttle_on,
  input logic       mod_en,
  input logic       spd,
  input logic [7:0] run_len,
  input logic [7:0] susp_len,
  input logic       susp_n
);
  p_disabled_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> susp_n);

  p_speedup_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spd |=> susp_n);

  p_hold_off_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && throttle_on) |=> $stable(susp_n));

  p_zero_lengths_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_len == 8'd0 && susp_len == 8'd0 && susp_n) |=> susp_n);

  p_susp_needs_throttle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(susp_n) |-> $past(throttle_on));
endmodule

bind suspmod_throttle suspmod_checker u_chk (
  .clk(clk), .rst_n(core_rst_n), .tick(tick_base), .throttle_on(throttle_on),
  .mod_en(regs.modcfg[0]), .spd(spd_any), .run_len(regs.run_len),
  .susp_len(regs.susp_len), .susp_n(susp_n)
);

// File: tb/sim_suspmod_throttle.sv
`timescale 1ns/1ps
module sim_suspmod_throttle;
  localparam int TDIV = 4;
  localparam int MST = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq_evt = 1'b0;
  logic vid_evt = 1'b0;
  logic susp_n;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit started = 0;

  always #4 clk = ~clk;

  suspmod_throttle #(.TICK_DIV(TDIV), .MS_TICKS(MST)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_evt(irq_evt),
    .vid_evt(vid_evt), .susp_n(susp_n)
  );

  // behavioural reference: plain integers per requirement
  int m_sync [$];
  int m_pm, m_irqd, m_vidd, m_run, m_sus, m_cfg;
  int m_div, m_msc, m_irqt, m_vidt;
  int m_state;   // 0 idle, 1 run, 2 suspended
  int m_rem;
  bit m_susp_n = 1;

  task automatic m_clear();
    m_pm = 0; m_irqd = 0; m_vidd = 0; m_run = 0; m_sus = 0; m_cfg = 0;
    m_div = 0; m_msc = 0; m_irqt = 0; m_vidt = 0; m_state = 0; m_rem = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = {0, 0};
      m_clear();
      started = 1;
    end else begin
      if (m_sync[1] == 1) begin
        bit tick, msk, spd, thr;
        tick = (m_div == TDIV - 1);
        msk = tick && (m_msc == MST - 1);
        spd = ((m_pm >> 3) & 1) && m_irqt != 0 || ((m_pm >> 4) & 1) && m_vidt != 0;
        thr = (m_cfg & 1) && !spd;
        if (!thr) begin
          m_state = 0; m_rem = 0;
        end else if (tick) begin
          if (m_rem > 1) m_rem--;
          else begin
            if (m_state != 1 && m_run != 0) begin m_state = 1; m_rem = m_run; end
            else if (m_sus != 0) begin m_state = 2; m_rem = m_sus; end
            else if (m_run != 0) begin m_state = 1; m_rem = m_run; end
            else begin m_state = 0; m_rem = 0; end
          end
        end
        if (irq_evt && ((m_pm >> 3) & 1)) m_irqt = m_irqd;
        else if (msk && m_irqt > 0) m_irqt--;
        if (vid_evt && ((m_pm >> 4) & 1)) m_vidt = m_vidd;
        else if (msk && m_vidt > 0) m_vidt--;
        if (reg_we) begin
          case (reg_addr)
            8'h80: m_pm = reg_wdata;
            8'h8C: m_irqd = reg_wdata;
            8'h8D: m_vidd = reg_wdata;
            8'h94: m_run = reg_wdata;
            8'h95: m_sus = reg_wdata;
            8'h96: m_cfg = reg_wdata;
            default: ;
          endcase
        end
        if (tick) m_msc = (m_msc == MST - 1) ? 0 : m_msc + 1;
        m_div = tick ? 0 : m_div + 1;
      end
      m_sync[1] = m_sync[0];
      m_sync[0] = 1;
    end
    m_susp_n = (m_state != 2);
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (susp_n !== m_susp_n) begin
        errors++;
        $display("FAIL %s: susp_n actual=%b expected=%b at cycle %0d", cur_req, susp_n, m_susp_n, cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read 0x%02h actual=0x%02h expected=0x%02h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic pulse_irq();
    @(negedge clk); irq_evt = 1'b1;
    @(negedge clk); irq_evt = 1'b0;
  endtask

  task automatic pulse_vid();
    @(negedge clk); vid_evt = 1'b1;
    @(negedge clk); vid_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic exp, input string req);
    @(negedge clk);
    #1;
    checks++;
    if (susp_n !== exp) begin
      errors++;
      $display("FAIL %s: susp_n actual=%b expected=%b", req, susp_n, exp);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    cur_req = "R1";
    rd_chk(8'h80, 8'h00, "R1");
    rd_chk(8'h8C, 8'h00, "R1");
    rd_chk(8'h94, 8'h00, "R1");
    rd_chk(8'h96, 8'h00, "R1");
    expect_out(1'b1, "R1");

    cur_req = "R2";
    wr(8'h80, 8'hA5); wr(8'h8C, 8'h3C); wr(8'h8D, 8'hC3);
    wr(8'h94, 8'h5A); wr(8'h95, 8'h81);
    rd_chk(8'h80, 8'hA5, "R2");
    rd_chk(8'h8C, 8'h3C, "R2");
    rd_chk(8'h8D, 8'hC3, "R2");
    rd_chk(8'h94, 8'h5A, "R2");
    rd_chk(8'h95, 8'h81, "R2");
    wr(8'h90, 8'hFF);
    rd_chk(8'h90, 8'h00, "R2");
    rd_chk(8'h94, 8'h5A, "R2");
    wr(8'h80, 8'h00);

    cur_req = "R3";
    wr(8'h94, 8'd2); wr(8'h95, 8'd3);
    idle(60);
    expect_out(1'b1, "R3");

    cur_req = "R4";
    wr(8'h96, 8'h01);
    rd_chk(8'h96, 8'h01, "R4");
    idle(150);

    cur_req = "R6";
    idle(5);
    wr(8'h94, 8'd5);
    idle(3);
    wr(8'h95, 8'd1);
    idle(120);

    cur_req = "R5";
    wr(8'h95, 8'd0);
    idle(60);
    expect_out(1'b1, "R5");
    wr(8'h94, 8'd0); wr(8'h95, 8'd2);
    idle(60);
    expect_out(1'b0, "R5");
    wr(8'h95, 8'd0);
    idle(40);
    expect_out(1'b1, "R5");

    cur_req = "R7";
    wr(8'h94, 8'd1); wr(8'h95, 8'd3);
    wr(8'h8C, 8'd3);
    wr(8'h80, 8'h08);
    idle(30);
    pulse_irq();
    expect_out(1'b1, "R7");
    idle(35);
    pulse_irq();
    idle(30);
    expect_out(1'b1, "R7");
    cur_req = "R9";
    idle(80);
    cur_req = "R7";
    wr(8'h80, 8'h00);
    idle(10);
    pulse_irq();
    idle(60);

    cur_req = "R8";
    wr(8'h8D, 8'd2);
    wr(8'h80, 8'h10);
    idle(13);
    pulse_vid();
    expect_out(1'b1, "R8");
    idle(20);
    pulse_irq();
    idle(50);
    wr(8'h80, 8'h00);
    pulse_vid();
    idle(40);

    cur_req = "R10";
    wr(8'h80, 8'h07);
    pulse_irq();
    pulse_vid();
    idle(80);
    rd_chk(8'h80, 8'h07, "R10");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule